// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles using one shifting accumulator and one adder no wider than the operands. An accepted start copies the multiplicand into a holding register. It also loads the accumulator with the multiplier in its lower half and zeros in its upper half.

On each working cycle the accumulator's lowest bit decides whether the multiplicand is added into the upper half. The adder's carry, the sum and the remaining lower bits then move one place to the right. The multiplier bits drain out of the bottom as the product builds up from the top.

After as many working cycles as the operand has bits, the accumulator holds the full double-width product. A one-cycle completion pulse marks this point, and the result stays on the output until the next accepted start. A start that arrives while an operation is running is dropped.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy is 0, done is 0 and product is 0.
- R2: A start sampled high while busy is 0 is accepted: busy is 1 in the following cycle and the operands present in that start cycle are the ones multiplied.
- R3: When done is 1, product equals the unsigned product of the two accepted operands, with every one of its 16 bits kept, including results that need the adder's carry such as 255 x 255 = 65025.
- R4: After an accepted start, busy stays 1 for exactly 8 cycles (the operand width), and done is 1 in the cycle right after the last busy cycle.
- R5: done is high for one cycle per operation and is never high together with busy.
- R6: While busy is 0 and no start is accepted, product does not change, whatever happens on the operand inputs.
- R7: A start sampled while busy is 1 is ignored: the running operation keeps its operands, its timing and its result.
- R8: The worked case 147 x 85 gives 12495 (hex 30CF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication, sampled on the clock edge |
| multiplicand | input | 8 | Unsigned multiplicand, sampled with an accepted start |
| multiplier | input | 8 | Unsigned multiplier, sampled with an accepted start |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 16 | Accumulator contents; the final product once done has pulsed |

## Verification
The assertions check on every cycle that done is a lone pulse that never overlaps busy and follows a busy cycle. They check that every busy run lasts exactly the operand width, that an idle accumulator stays put, and that the value shown at done equals the product of the operands captured at the accepted start. Only the bench scenarios can show the sweep of operand values through the carry path and the worked 147 x 85 case. The bench scenarios also show that a second start in mid-operation leaves the running operation's result and timing intact, and that the reset state is correct.

// File: rtl/mult_pkg.sv
package mult_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/mult_addcarry.sv
module mult_addcarry #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] addend,
    input  logic         add_en,
    output logic [W-1:0] sum,
    output logic         carry
);

    logic [W:0] wide;

    always_comb begin
        if (add_en) begin
            wide = {1'b0, acc_hi} + {1'b0, addend};
        end else begin
            wide = {1'b0, acc_hi};
        end
    end

    assign sum   = wide[W-1:0];
    assign carry = wide[W];

endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
    import mult_pkg::*;
#(
    parameter int ITER = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(ITER) + 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    load       = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                step     = 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(ITER - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == PH_RUN);
    assign done = st_q.done;

endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
    parameter int OP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   multiplicand,
    input  logic [OP_W-1:0]   multiplier,
    output logic              busy,
    output logic              done,
    output logic [2*OP_W-1:0] product
);

    localparam int PW = 2 * OP_W;

    typedef struct packed {
        logic [PW-1:0]   acc;
        logic [OP_W-1:0] mcand;
    } dp_t;

    dp_t dp_d, dp_q;

    logic            load, step;
    logic [OP_W-1:0] sum;
    logic            carry;

    mult_ctrl #(.ITER(OP_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mult_addcarry #(.W(OP_W)) u_add (
        .acc_hi (dp_q.acc[PW-1:OP_W]),
        .addend (dp_q.mcand),
        .add_en (dp_q.acc[0]),
        .sum    (sum),
        .carry  (carry)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.acc   = {{OP_W{1'b0}}, multiplier};
            dp_d.mcand = multiplicand;
        end else if (step) begin
            dp_d.acc = {carry, sum, dp_q.acc[OP_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign product = dp_q.acc;

endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
    parameter int OP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   multiplicand,
    input logic [OP_W-1:0]   multiplier,
    input logic              busy,
    input logic              done,
    input logic [2*OP_W-1:0] product
);

    localparam int PW    = 2 * OP_W;
    localparam int CNT_W = $clog2(OP_W) + 2;

    logic [OP_W-1:0]  cap_a, cap_b;
    logic [CNT_W-1:0] run_cnt;
    logic [PW-1:0]    want;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else begin
            if (start && !busy) begin
                cap_a <= multiplicand;
                cap_b <= multiplier;
            end
            run_cnt <= busy ? run_cnt + 1'b1 : '0;
        end
    end

    assign want = {{OP_W{1'b0}}, cap_a} * {{OP_W{1'b0}}, cap_b};

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == want));

    assert_run_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CNT_W'(OP_W)));

    assert_run_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CNT_W'(OP_W)));

    assert_done_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind shift_add_mult shift_add_mult_chk #(.OP_W(OP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
);

// File: tb/test_shift_add_mult.sv
module test_shift_add_mult;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  multiplicand = '0;
    logic [7:0]  multiplier = '0;
    logic        busy, done;
    logic [15:0] product;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    shift_add_mult i_shift_add_mult (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .busy         (busy),
        .done         (done),
        .product      (product)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // one operation, optionally with a stray start in mid-run (R7)
    task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit stray);
        logic [15:0] exp_p;
        exp_p = 16'(a) * 16'(b);
        @(negedge clk);
        start = 1'b1; multiplicand = a; multiplier = b;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 32'(busy), 32'd1);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (stray && k == 2) begin
                start = 1'b1; multiplicand = ~a; multiplier = b ^ 8'h5A;
            end else begin
                start = 1'b0; multiplicand = a ^ 8'h33; multiplier = ~b;
            end
        end
        check("R4 still busy on last iteration", 32'(busy), 32'd1);
        check("R4 no early done", 32'(done), 32'd0);
        @(negedge clk);
        start = 1'b0;
        check("R4 done after 8 busy cycles", 32'(done), 32'd1);
        check("R5 busy low with done", 32'(busy), 32'd0);
        check(stray ? "R7 result unaffected by stray start" : "R3 product", 32'(product), 32'(exp_p));
        multiplicand = ~multiplicand; multiplier = multiplier + 8'd7;
        @(negedge clk);
        check("R5 done is one cycle", 32'(done), 32'd0);
        check("R6 product held while idle", 32'(product), 32'(exp_p));
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 32'(busy), 32'd0);
        check("R1 done in reset", 32'(done), 32'd0);
        check("R1 product in reset", 32'(product), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 product after reset", 32'(product), 32'd0);

        // R8 worked case
        run_op(8'd147, 8'd85, 1'b0);
        check("R8 147x85", 32'(product), 32'd12495);

        // R3 carry corners
        run_op(8'd255, 8'd255, 1'b0);
        run_op(8'd0, 8'd255, 1'b0);
        run_op(8'd255, 8'd1, 1'b0);

        // R7 stray starts
        run_op(8'd200, 8'd99, 1'b1);
        run_op(8'd255, 8'd255, 1'b1);

        // R6 long idle with changing inputs
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            multiplicand = 8'(k * 37); multiplier = 8'(k * 91);
            check("R6 idle product hold", 32'(product), 32'd65025);
        end

        // R3 sweep: every multiplicand against a stride of multipliers
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b += 17) begin
                run_op(8'(a), 8'(b), 1'b0);
            end
        end
        // R3 sweep: every multiplier against edge multiplicands
        for (int b = 0; b < 256; b++) begin
            run_op(8'd1, 8'(b), 1'b0);
            run_op(8'd128, 8'(b), 1'b0);
            run_op(8'd255, 8'(b), 1'b0);
        end
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            n_fail++;
            $display("FAIL watchdog: got %0d expected below %0d", cycles, 150000);
            finish_run();
        end
    end

endmodule